// File: doc/BRIEF.md
# Opcode-Mapped Microprogram Sequencer

This block is the control core of a microprogrammed processor. A fetched 8-bit opcode is turned into the 12-bit start address of a microroutine by a small mapping stage. Most of the address bits are copied from the opcode, and one bit comes from an XOR gate. The sequencer then walks the control store from that address, one microinstruction per clock, and drives the control word of each step onto a registered output.

The control store is read-only and fixed at build time. Its contents are computed from the microaddress, so no table has to be written out. Every word holds a 16-bit control field and an end-of-routine flag. When the sequencer reaches a word with the flag set, it returns to idle and pulses `done`. The opcode input acts as a stream input: `busy` is its back-pressure signal. An opcode is taken on a clock edge where `opc_valid` is high and `busy` is low. A strobe that arrives while `busy` is high is dropped, and the source must hold or present the opcode again once `busy` falls.

Top module: `useq_sequencer`

## Requirements
- R1: The start address copies opcode bits: start[11:8] = opc[7:4], start[7] = opc[3], start[6] = opc[2], start[4] = opc[1], and start[3:0] = 0.
- R2: Bit 5 of the start address is the XOR of opcode bit 3 and opcode bit 0.
- R3: The control store word at address a has control field {4'hA, a[11:0]}. Its end flag is set when a[3:0] equals a[5:4], so a routine that starts at s is s[5:4]+1 words long.
- R4: Each clock while executing, the microprogram counter steps up by one, so consecutive control words carry consecutive addresses.
- R5: When `opc_valid` is high and `busy` is low at a clock edge, the opcode is accepted and `busy` is high after that edge. The first control word appears on `ctrl_word` one cycle later.
- R6: `done` is high for exactly one cycle, in the same cycle as the last control word of a routine. `busy` is low in that cycle.
- R7: An `opc_valid` strobe while `busy` is high is ignored, and the running routine continues unchanged.
- R8: A synchronous reset makes `busy` low, `done` low and `ctrl_word` zero on the next cycle, even in the middle of a routine.
- R9: `ctrl_word` is zero in every cycle that does not carry a control word of a routine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opc_valid | input | 1 | Opcode strobe |
| opc | input | 8 | Opcode to execute |
| ctrl_word | output | 16 | Registered control word of the current step |
| busy | output | 1 | Routine executing; new opcodes are refused |
| done | output | 1 | One-cycle pulse that marks the last step |

## Verification
The bench sends opcodes chosen to give routine lengths of one to four words. Setting and clearing opcode bits 3 and 0 separately shows whether the XOR bit is computed and whether the copied bits sit in the right places. Opcodes 00 and FF test the extreme bit patterns. On every other routine the bench holds the complemented opcode on the strobe while busy. If the sequencer accepted that opcode, the sequence of control words would change. A reset part-way through a four-word routine shows that the sequencer aborts the routine cleanly.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int OPC_W  = 8;
  localparam int UA_W   = 12;
  localparam int CTRL_W = 16;
  localparam int SLOT_W = 4;
  localparam int TAG_W  = CTRL_W - UA_W;
  localparam logic [TAG_W-1:0] CTRL_TAG = 4'hA;

  typedef struct packed {
    logic              last;
    logic [CTRL_W-1:0] ctrl;
  } uword_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} useq_state_e;
endpackage

// File: rtl/useq_map.sv
module useq_map
  import useq_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output logic [UA_W-1:0]  start
);
  logic xbit;
  assign xbit  = opc[3] ^ opc[0];
  assign start = {opc[7:4], opc[3], opc[2], xbit, opc[1], {SLOT_W{1'b0}}};
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [UA_W-1:0] addr,
  output uword_t          word
);
  logic [SLOT_W-1:0] last_off;

  always_comb begin
    last_off  = {{(SLOT_W-2){1'b0}}, addr[5:4]};
    word.last = (addr[SLOT_W-1:0] == last_off);
    word.ctrl = {CTRL_TAG, addr};
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              opc_valid,
  input  logic [UA_W-1:0]   start,
  input  uword_t            word,
  output logic [UA_W-1:0]   upc,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              busy,
  output logic              done
);
  useq_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      upc    <= '0;
      ctrl_q <= '0;
      done   <= 1'b0;
    end else begin
      done   <= 1'b0;
      ctrl_q <= '0;
      case (state)
        ST_IDLE: begin
          if (opc_valid) begin
            upc   <= start;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          ctrl_q <= word.ctrl;
          if (word.last) begin
            state <= ST_IDLE;
            upc   <= '0;
            done  <= 1'b1;
          end else begin
            upc <= upc + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              opc_valid,
  input  logic [OPC_W-1:0]  opc,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic              busy,
  output logic              done
);
  logic [UA_W-1:0] start;
  logic [UA_W-1:0] upc;
  uword_t          word;

  useq_map u_map (.opc(opc), .start(start));

  useq_store u_store (.addr(upc), .word(word));

  useq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opc_valid(opc_valid), .start(start),
    .word(word), .upc(upc), .ctrl_q(ctrl_word), .busy(busy), .done(done)
  );
endmodule

// File: rtl/useq_checker.sv
module useq_checker (
  input logic        clk,
  input logic        rst,
  input logic        opc_valid,
  input logic [7:0]  opc,
  input logic [15:0] ctrl_word,
  input logic        busy,
  input logic        done
);
  AST_START_COPY: assert property (@(posedge clk) disable iff (rst)
    (!busy && opc_valid) |=> ##1 (ctrl_word[11:8] == $past(opc[7:4], 2))); // R1
  AST_START_XOR: assert property (@(posedge clk) disable iff (rst)
    (!busy && opc_valid) |=> ##1 (ctrl_word[5] == ($past(opc[3], 2) ^ $past(opc[0], 2)))); // R2
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> (ctrl_word[11:0] == $past(ctrl_word[11:0]) + 12'd1)); // R4
  AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!busy && opc_valid) |=> busy); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_END: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R6
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!busy && !done && ctrl_word == 16'h0)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (ctrl_word == 16'h0)); // R9
endmodule

bind useq_sequencer useq_checker u_chk (
  .clk(clk), .rst(rst), .opc_valid(opc_valid), .opc(opc),
  .ctrl_word(ctrl_word), .busy(busy), .done(done)
);

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {opcode, expected routine length}
  localparam logic [15:0] VEC [NV] = '{
    16'h00_01, 16'hFF_02, 16'h09_01, 16'h08_03,
    16'h01_03, 16'h3A_04, 16'hC5_03, 16'h72_02
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        opc_valid;
  logic [7:0]  opc;
  logic [15:0] ctrl_word;
  logic        busy;
  logic        done;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_sequencer dut_i (
    .clk(clk), .rst(rst), .opc_valid(opc_valid), .opc(opc),
    .ctrl_word(ctrl_word), .busy(busy), .done(done)
  );

  function automatic logic [11:0] exp_start(input logic [7:0] o);
    return {o[7:4], o[3], o[2], o[3] ^ o[0], o[1], 4'b0000}; // R1 R2
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_op(input logic [7:0] o, input int len, input bit ign);
    logic [11:0] s;
    s = exp_start(o);
    chk("R3 length", 32'(int'(s[5:4]) + 1), 32'(len));
    @(negedge clk); opc_valid = 1'b1; opc = o;
    @(posedge clk); #1;
    chk("R5 busy after accept", 32'(busy), 32'd1);
    chk("R9 ctrl zero before first word", 32'(ctrl_word), 32'd0);
    @(negedge clk);
    if (ign) begin opc_valid = 1'b1; opc = ~o; end // R7 strobe while busy
    else opc_valid = 1'b0;
    for (int k = 0; k < len; k++) begin
      @(posedge clk); #1;
      chk("R1/R2/R3/R4 ctrl word", 32'(ctrl_word), 32'({4'hA, s + 12'(k)}));
      chk("R6 done", 32'(done), 32'(k == len - 1));
      chk("R6 busy", 32'(busy), 32'(k != len - 1));
      @(negedge clk);
      if (k == len - 1) opc_valid = 1'b0;
    end
    @(posedge clk); #1;
    chk("R9 ctrl zero idle", 32'(ctrl_word), 32'd0);
    chk("R6 done single pulse", 32'(done), 32'd0);
    chk("R7 ignored strobe left idle", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; opc_valid = 1'b0; opc = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset ctrl", 32'(ctrl_word), 32'd0);
    chk("R8 reset busy", 32'(busy), 32'd0);
    chk("R8 reset done", 32'(done), 32'd0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][15:8], int'(VEC[i][7:0]), (i % 2) == 1);

    // R8: reset in the middle of a four-word routine
    @(negedge clk); opc_valid = 1'b1; opc = 8'h3A;
    @(negedge clk); opc_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R8 mid-routine ctrl", 32'(ctrl_word), 32'd0);
    chk("R8 mid-routine busy", 32'(busy), 32'd0);
    chk("R8 mid-routine done", 32'(done), 32'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R9 ctrl zero after reset", 32'(ctrl_word), 32'd0);

    // R1/R2 after reset: routine restarts cleanly
    run_op(8'h08, 3, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule